// File: doc/BRIEF.md
# Character Display Plane Controller

This block holds the contents of a 40-column by 13-row character screen. It has one byte-wide plane of character codes and one byte-wide plane of colour attributes, each 520 cells deep. A CPU reaches both planes and a small set of control registers through a byte bus with a select strobe. A separate display port takes a linear cell index and returns that cell's character and colour.

Software can also hand whole-screen or windowed edits to a hardware engine. Writing an operation code to the command register starts a walk over the selected cells, one cell per clock. Each cell gets a clear, shift, rotate, reverse-video or colour-fill update, applied to both planes together. A window comes from four rectangle registers and is cut down to the screen edges before use. A second storage pair holds a snapshot of both planes. While the pause flag is set, the display port shows the snapshot instead of live data, so the screen does not tear during multi-step redraws.

Top module: `tdc_text_ctrl`

## Requirements
- R1: After reset every register reads 0, no operation is running, every character cell holds 0x20 and every colour cell holds 0, in both the live planes and the snapshot.
- R2: Register offsets (bus_addr[11:10]=00, offset in bus_addr[3:0]) are: 0 command, 1 pause, 2 frame, 3 window X, 4 window Y, 5 window width, 6 window height, 7 draw colour, 8 mode. X, Y, width and height read back as written. Draw colour keeps only its low 4 bits. Pause and mode keep only bit 0, and mode 0 is the reset value.
- R3: Command 0x00 sets every character in the area to 0x20 and every colour to the draw colour.
- R4: Commands 0x01, 0x02, 0x03 and 0x04 shift the area left, right, up and down by one cell. The vacated edge cells take 0x20 and the draw colour.
- R5: Commands 0x05, 0x06, 0x07 and 0x08 rotate the area left, right, up and down by one cell, and the cell pushed out at one edge re-enters at the opposite edge.
- R6: Command 0x09 inverts bit 7 of every character in the area and leaves colours unchanged. Command 0x0A writes the draw colour to every colour cell in the area and leaves characters unchanged.
- R7: Setting bit 4 of the command (0x10 to 0x1A) limits the same operation to the window. Cells outside the window are not changed.
- R8: The window is empty when X is 40 or more, Y is 13 or more, or width or height is 0, and then the command does nothing. Otherwise the width used is min(W, 40-X) and the height used is min(H, 13-Y).
- R9: Bit 0 of the command offset reads 1 while an operation or snapshot copy is running. Command writes, frame writes and plane writes made during that time are ignored. Command codes with bits 7:5 non-zero or a low nibble above 0x0A are ignored.
- R10: Any write to the frame offset copies both live planes into the snapshot. While pause is 1 the display port returns snapshot data, and while pause is 0 it returns live data.
- R11: bus_addr[11:10]=01 reaches the character plane and 10 reaches the colour plane, at linear index row*40+col in bus_addr[9:0]. Bus read data appears on the clock edge after the strobe.
- R12: The display port returns the cell selected by disp_idx on the clock edge after the index is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Region in bits 11:10, then register offset or cell index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| disp_idx | input | 10 | Display cell index |
| disp_char | output | 8 | Character at disp_idx (live or snapshot) |
| disp_color | output | 8 | Colour at disp_idx (live or snapshot) |

## Verification
The assertions assume that a bus access lasts one strobe cycle with a stable address. They also assume the window registers are not rewritten in the same cycle as a command, which a single-port bus guarantees. Given that, every engine write has to land inside the screen and the clamped window, and the busy state has to end only on the walk's final cell. The stimulus uses one strobe per access and starts each operation only after the bench has seen busy read back as 0, with one exception. That exception is the test that writes commands, frames and cells on purpose while busy, to show they are dropped.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
   typedef enum logic [3:0] {
      OP_CLR  = 4'h0, OP_SHL = 4'h1, OP_SHR = 4'h2, OP_SHU = 4'h3,
      OP_SHD  = 4'h4, OP_ROL = 4'h5, OP_ROR = 4'h6, OP_ROU = 4'h7,
      OP_ROD  = 4'h8, OP_INV = 4'h9, OP_FILL = 4'hA, OP_COPY = 4'hF
   } op_e;

   localparam logic [3:0] OP_LAST = 4'hA;

   // column-major walk for the vertical moves
   function automatic logic op_vert(op_e o);
      return (o == OP_SHU) || (o == OP_SHD) || (o == OP_ROU) || (o == OP_ROD);
   endfunction

   // walk the inner axis from high to low
   function automatic logic op_desc(op_e o);
      return (o == OP_SHR) || (o == OP_SHD) || (o == OP_ROR) || (o == OP_ROD);
   endfunction

   function automatic logic op_shift(op_e o);
      return (o >= OP_SHL) && (o <= OP_SHD);
   endfunction

   function automatic logic op_rot(op_e o);
      return (o >= OP_ROL) && (o <= OP_ROD);
   endfunction
endpackage

// File: rtl/tdc_clamp.sv
module tdc_clamp #(
   parameter int COLS = 40,
   parameter int ROWS = 13,
   parameter int LW   = 6
) (
   input  logic          full,
   input  logic [7:0]    x,
   input  logic [7:0]    y,
   input  logic [7:0]    w,
   input  logic [7:0]    h,
   output logic          ok,
   output logic [LW-1:0] ox,
   output logic [LW-1:0] oy,
   output logic [LW-1:0] ow,
   output logic [LW-1:0] oh
);
   logic [8:0] room_x, room_y;

   always_comb begin
      room_x = 9'(COLS) - {1'b0, x};
      room_y = 9'(ROWS) - {1'b0, y};
      if (full) begin
         ok = 1'b1;
         ox = '0;
         oy = '0;
         ow = LW'(COLS);
         oh = LW'(ROWS);
      end else begin
         ok = ({1'b0, x} < 9'(COLS)) && ({1'b0, y} < 9'(ROWS)) &&
              (w != 8'd0) && (h != 8'd0);
         ox = LW'(x);
         oy = LW'(y);
         ow = ({1'b0, w} > room_x) ? LW'(room_x) : LW'(w);
         oh = ({1'b0, h} > room_y) ? LW'(room_y) : LW'(h);
      end
   end
endmodule

// File: rtl/tdc_walker.sv
module tdc_walker #(
   parameter int LW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          vert_in,
   input  logic          desc_in,
   input  logic [LW-1:0] x_in,
   input  logic [LW-1:0] y_in,
   input  logic [LW-1:0] w_in,
   input  logic [LW-1:0] h_in,
   output logic          active,
   output logic [LW-1:0] row,
   output logic [LW-1:0] col,
   output logic          first,
   output logic          last_in,
   output logic          last_cell
);
   logic          vert_q, desc_q;
   logic [LW-1:0] x_q, y_q, w_q, h_q, i_q, o_q;
   logic [LW-1:0] ilen, olen, pos;

   always_comb begin
      ilen      = vert_q ? h_q : w_q;
      olen      = vert_q ? w_q : h_q;
      pos       = desc_q ? LW'(ilen - LW'(1) - i_q) : i_q;
      row       = vert_q ? LW'(y_q + pos) : LW'(y_q + o_q);
      col       = vert_q ? LW'(x_q + o_q) : LW'(x_q + pos);
      first     = (i_q == '0);
      last_in   = (i_q == LW'(ilen - LW'(1)));
      last_cell = last_in && (o_q == LW'(olen - LW'(1)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         vert_q <= 1'b0;
         desc_q <= 1'b0;
         x_q <= '0; y_q <= '0; w_q <= '0; h_q <= '0;
         i_q <= '0; o_q <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            vert_q <= vert_in;
            desc_q <= desc_in;
            x_q <= x_in; y_q <= y_in; w_q <= w_in; h_q <= h_in;
            i_q <= '0;
            o_q <= '0;
         end
      end else if (last_cell) begin
         active <= 1'b0;
      end else if (last_in) begin
         i_q <= '0;
         o_q <= LW'(o_q + LW'(1));
      end else begin
         i_q <= LW'(i_q + LW'(1));
      end
   end
endmodule

// File: rtl/tdc_text_ctrl.sv
module tdc_text_ctrl
   import tdc_pkg::*;
#(
   parameter int         COLS     = 40,
   parameter int         ROWS     = 13,
   parameter logic [7:0] BLANK    = 8'h20,
   parameter bit         DISP_REG = 1'b1,
   localparam int        CELLS    = COLS * ROWS,
   localparam int        IDXW     = $clog2(CELLS),
   localparam int        AW       = IDXW + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [7:0]      bus_wdata,
   output logic [7:0]      bus_rdata,
   input  logic [IDXW-1:0] disp_idx,
   output logic [7:0]      disp_char,
   output logic [7:0]      disp_color
);
   localparam int XW = $clog2(COLS + 1);
   localparam int YW = $clog2(ROWS + 1);
   localparam int LW = (XW > YW) ? XW : YW;

   if (COLS < 2 || ROWS < 2 || COLS > 255 || ROWS > 255) begin : g_bad_geom
      $error("tdc_text_ctrl: COLS and ROWS must lie in 2..255");
   end

   // storage
   logic [7:0] lv_c [CELLS];
   logic [7:0] lv_k [CELLS];
   logic [7:0] sn_c [CELLS];
   logic [7:0] sn_k [CELLS];

   // register file
   logic       pause_q, mode_q;
   logic [3:0] colour_q;
   logic [7:0] rx_q, ry_q, rw_q, rh_q;
   op_e        op_q;
   logic [7:0] tmp_c, tmp_k;

   // bus decode
   logic [1:0]      region;
   logic [3:0]      off;
   logic [IDXW-1:0] bidx;
   logic            bidx_ok, reg_wr, cmd_wr, frame_wr, code_ok;
   logic            start_cmd, start_copy;

   // clamp and walker
   logic          c_ok;
   logic [LW-1:0] c_x, c_y, c_w, c_h;
   logic          w_active, w_first, w_last_in, w_last_cell;
   logic [LW-1:0] w_row, w_col;

   always_comb begin
      region     = bus_addr[AW-1:AW-2];
      off        = bus_addr[3:0];
      bidx       = bus_addr[IDXW-1:0];
      bidx_ok    = (32'(bidx) < CELLS);
      reg_wr     = bus_sel && bus_wr && (region == 2'b00);
      cmd_wr     = reg_wr && (off == 4'd0);
      frame_wr   = reg_wr && (off == 4'd2);
      code_ok    = (bus_wdata[7:5] == 3'b000) && (bus_wdata[3:0] <= OP_LAST);
      start_cmd  = cmd_wr && code_ok && !w_active && c_ok;
      start_copy = frame_wr && !w_active;
   end

   tdc_clamp #(.COLS(COLS), .ROWS(ROWS), .LW(LW)) clamp_i (
      .full (frame_wr || !bus_wdata[4]),
      .x    (rx_q), .y (ry_q), .w (rw_q), .h (rh_q),
      .ok   (c_ok),
      .ox   (c_x), .oy (c_y), .ow (c_w), .oh (c_h)
   );

   tdc_walker #(.LW(LW)) walk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_cmd || start_copy),
      .vert_in   (!frame_wr && op_vert(op_e'(bus_wdata[3:0]))),
      .desc_in   (!frame_wr && op_desc(op_e'(bus_wdata[3:0]))),
      .x_in      (c_x), .y_in (c_y), .w_in (c_w), .h_in (c_h),
      .active    (w_active),
      .row       (w_row),
      .col       (w_col),
      .first     (w_first),
      .last_in   (w_last_in),
      .last_cell (w_last_cell)
   );

   // per-cell update value
   logic [IDXW-1:0] idx, nb, nb_safe;
   logic [7:0]      nc, nk;

   always_comb begin
      idx = IDXW'(IDXW'(w_row) * IDXW'(COLS) + IDXW'(w_col));
      if (op_vert(op_q)) nb = op_desc(op_q) ? IDXW'(idx - IDXW'(COLS)) : IDXW'(idx + IDXW'(COLS));
      else               nb = op_desc(op_q) ? IDXW'(idx - IDXW'(1))    : IDXW'(idx + IDXW'(1));
      nb_safe = w_last_in ? idx : nb;
      nc = lv_c[idx];
      nk = lv_k[idx];
      if (op_q == OP_CLR) begin
         nc = BLANK;
         nk = {4'b0, colour_q};
      end else if (op_shift(op_q)) begin
         nc = w_last_in ? BLANK : lv_c[nb_safe];
         nk = w_last_in ? {4'b0, colour_q} : lv_k[nb_safe];
      end else if (op_rot(op_q)) begin
         if (!w_last_in) begin
            nc = lv_c[nb_safe];
            nk = lv_k[nb_safe];
         end else if (!w_first) begin
            nc = tmp_c;
            nk = tmp_k;
         end
      end else if (op_q == OP_INV) begin
         nc = lv_c[idx] ^ 8'h80;
      end else if (op_q == OP_FILL) begin
         nk = {4'b0, colour_q};
      end
   end

   // registers and planes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pause_q  <= 1'b0;
         mode_q   <= 1'b0;
         colour_q <= '0;
         rx_q <= '0; ry_q <= '0; rw_q <= '0; rh_q <= '0;
         op_q  <= OP_CLR;
         tmp_c <= '0;
         tmp_k <= '0;
         for (int i = 0; i < CELLS; i++) begin
            lv_c[i] <= BLANK; lv_k[i] <= '0;
            sn_c[i] <= BLANK; sn_k[i] <= '0;
         end
      end else begin
         if (reg_wr) begin
            case (off)
               4'd1: pause_q  <= bus_wdata[0];
               4'd3: rx_q     <= bus_wdata;
               4'd4: ry_q     <= bus_wdata;
               4'd5: rw_q     <= bus_wdata;
               4'd6: rh_q     <= bus_wdata;
               4'd7: colour_q <= bus_wdata[3:0];
               4'd8: mode_q   <= bus_wdata[0];
               default: ;
            endcase
         end
         if (start_copy)     op_q <= OP_COPY;
         else if (start_cmd) op_q <= op_e'(bus_wdata[3:0]);
         if (w_active && w_first) begin
            tmp_c <= lv_c[idx];
            tmp_k <= lv_k[idx];
         end
         if (w_active) begin
            if (op_q == OP_COPY) begin
               sn_c[idx] <= lv_c[idx];
               sn_k[idx] <= lv_k[idx];
            end else begin
               lv_c[idx] <= nc;
               lv_k[idx] <= nk;
            end
         end else if (bus_sel && bus_wr && bidx_ok) begin
            if (region == 2'b01) lv_c[bidx] <= bus_wdata;
            if (region == 2'b10) lv_k[bidx] <= bus_wdata;
         end
      end
   end

   // bus read
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_sel && !bus_wr) begin
         bus_rdata <= '0;
         if (region == 2'b00) begin
            case (off)
               4'd0: bus_rdata <= {7'b0, w_active};
               4'd1: bus_rdata <= {7'b0, pause_q};
               4'd3: bus_rdata <= rx_q;
               4'd4: bus_rdata <= ry_q;
               4'd5: bus_rdata <= rw_q;
               4'd6: bus_rdata <= rh_q;
               4'd7: bus_rdata <= {4'b0, colour_q};
               4'd8: bus_rdata <= {7'b0, mode_q};
               default: ;
            endcase
         end else if (bidx_ok && region == 2'b01) begin
            bus_rdata <= lv_c[bidx];
         end else if (bidx_ok && region == 2'b10) begin
            bus_rdata <= lv_k[bidx];
         end
      end
   end

   // display port
   logic       d_ok;
   logic [7:0] d_c, d_k;
   always_comb begin
      d_ok = (32'(disp_idx) < CELLS);
      d_c  = '0;
      d_k  = '0;
      if (d_ok) begin
         d_c = pause_q ? sn_c[disp_idx] : lv_c[disp_idx];
         d_k = pause_q ? sn_k[disp_idx] : lv_k[disp_idx];
      end
   end

   if (DISP_REG) begin : g_disp_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            disp_char  <= '0;
            disp_color <= '0;
         end else begin
            disp_char  <= d_c;
            disp_color <= d_k;
         end
      end
   end else begin : g_disp_comb
      always_comb begin
         disp_char  = d_c;
         disp_color = d_k;
      end
   end
endmodule

// File: rtl/tdc_text_ctrl_chk.sv
module tdc_text_ctrl_chk #(
   parameter int COLS = 40,
   parameter int ROWS = 13,
   parameter int LW   = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          active,
   input logic          last_cell,
   input logic          cmd_wr,
   input logic          frame_wr,
   input logic [3:0]    op_q,
   input logic [LW-1:0] row,
   input logic [LW-1:0] col,
   input logic          c_ok,
   input logic [LW-1:0] c_x,
   input logic [LW-1:0] c_y,
   input logic [LW-1:0] c_w,
   input logic [LW-1:0] c_h
);
   // R8: a usable window never reaches past the screen edge
   a_r8_clamp_fits: assert property (@(posedge clk) disable iff (!rst_n)
      c_ok |-> ((32'(c_x) + 32'(c_w) <= COLS) && (32'(c_y) + 32'(c_h) <= ROWS)));

   // R7: the engine only ever touches cells on the screen
   a_r7_walk_on_screen: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ((32'(row) < ROWS) && (32'(col) < COLS)));

   // R9: a command written while busy leaves the running operation alone
   a_r9_drop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cmd_wr) |=> $stable(op_q));

   // R9: busy ends only after the final cell of the walk
   a_r9_busy_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(last_cell));

   // R10: a snapshot copy begins only from a frame write
   a_r10_copy_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(active) && op_q == 4'hF) |-> $past(frame_wr));
endmodule

bind tdc_text_ctrl tdc_text_ctrl_chk #(.COLS(COLS), .ROWS(ROWS), .LW(LW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .active    (w_active),
   .last_cell (w_last_cell),
   .cmd_wr    (cmd_wr),
   .frame_wr  (frame_wr),
   .op_q      (op_q),
   .row       (w_row),
   .col       (w_col),
   .c_ok      (c_ok),
   .c_x       (c_x),
   .c_y       (c_y),
   .c_w       (c_w),
   .c_h       (c_h)
);

// File: tb/tdc_text_ctrl_tb_top.sv
module tdc_text_ctrl_tb_top;
   localparam int COLS  = 40;
   localparam int ROWS  = 13;
   localparam int CELLS = COLS * ROWS;

   logic        clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n, bus_sel, bus_wr;
   logic [11:0] bus_addr;
   logic [7:0]  bus_wdata, bus_rdata;
   logic [9:0]  disp_idx;
   logic [7:0]  disp_char, disp_color;

   tdc_text_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .disp_idx(disp_idx), .disp_char(disp_char), .disp_color(disp_color)
   );

   int n_chk = 0, n_bad = 0;
   int m_c[CELLS], m_k[CELLS], s_c[CELLS], s_k[CELLS], o_c[CELLS], o_k[CELLS];
   int m_pause = 0, m_colour = 0, rx = 0, ry = 0, rw = 0, rh = 0;
   bit done = 0;

   task automatic check(string req, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(int addr, int data);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 12'(addr); bus_wdata = 8'(data);
      @(posedge clk);
      #1 bus_sel = 0; bus_wr = 0;
   endtask

   task automatic bus_read(int addr, output int d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = 12'(addr);
      @(negedge clk);
      bus_sel = 0;
      d = int'(bus_rdata);
   endtask

   task automatic set_reg(int off, int val);
      bus_write(off, val);
      case (off)
         1: m_pause = val & 1;
         3: rx = val; 4: ry = val; 5: rw = val; 6: rh = val;
         7: m_colour = val & 15;
         default: ;
      endcase
   endtask

   task automatic wait_idle(string req);
      int d, guard;
      guard = 0;
      bus_read(0, d);
      while ((d & 1) && guard < 3000) begin
         bus_read(0, d);
         guard++;
      end
      check(req, d & 1, 0, "busy clears");
   endtask

   task automatic fill_planes(int seed);
      for (int i = 0; i < CELLS; i++) begin
         m_c[i] = (i * 7 + seed) & 255;
         bus_write(12'h400 + i, m_c[i]);
      end
      for (int i = 0; i < CELLS; i++) begin
         m_k[i] = (i * 3 + seed * 5) & 255;
         bus_write(12'h800 + i, m_k[i]);
      end
   endtask

   // pipelined sweep: one index per cycle, data sampled a cycle later
   task automatic compare_all(string req);
      int bad_a, bad_e, bad_i;
      bad_i = -1; bad_a = 0; bad_e = 0;
      for (int i = 0; i <= CELLS; i++) begin
         @(negedge clk);
         if (i > 0) begin
            int ec, ek;
            ec = m_pause ? s_c[i-1] : m_c[i-1];
            ek = m_pause ? s_k[i-1] : m_k[i-1];
            if (bad_i < 0 && (int'(disp_char) != ec || int'(disp_color) != ek)) begin
               bad_i = i - 1;
               bad_a = (int'(disp_char) << 8) | int'(disp_color);
               bad_e = (ec << 8) | ek;
            end
         end
         if (i < CELLS) disp_idx = 10'(i);
      end
      check(req, bad_a, bad_e, $sformatf("screen cell %0d char:colour", bad_i));
   endtask

   // semantic model of one command
   task automatic model_cmd(int code);
      int op, x0, y0, w, h, x1, y1, i, src;
      if ((code & 8'hE0) != 0 || (code & 15) > 10) return;
      op = code & 15;
      if (code & 16) begin
         if (rx >= COLS || ry >= ROWS || rw == 0 || rh == 0) return;
         x0 = rx; y0 = ry;
         w = (rw > COLS - rx) ? COLS - rx : rw;
         h = (rh > ROWS - ry) ? ROWS - ry : rh;
      end else begin
         x0 = 0; y0 = 0; w = COLS; h = ROWS;
      end
      x1 = x0 + w - 1; y1 = y0 + h - 1;
      o_c = m_c; o_k = m_k;
      for (int r = y0; r <= y1; r++) begin
         for (int c = x0; c <= x1; c++) begin
            i = r * COLS + c;
            src = -1;
            case (op)
               1: src = (c < x1) ? i + 1 : -1;
               2: src = (c > x0) ? i - 1 : -1;
               3: src = (r < y1) ? i + COLS : -1;
               4: src = (r > y0) ? i - COLS : -1;
               5: src = (c == x1) ? r * COLS + x0 : i + 1;
               6: src = (c == x0) ? r * COLS + x1 : i - 1;
               7: src = (r == y1) ? y0 * COLS + c : i + COLS;
               8: src = (r == y0) ? y1 * COLS + c : i - COLS;
               default: ;
            endcase
            if (op == 0) begin
               m_c[i] = 8'h20; m_k[i] = m_colour;
            end else if (op == 9) begin
               m_c[i] = o_c[i] ^ 8'h80;
            end else if (op == 10) begin
               m_k[i] = m_colour;
            end else if (src < 0) begin
               m_c[i] = 8'h20; m_k[i] = m_colour;
            end else begin
               m_c[i] = o_c[src]; m_k[i] = o_k[src];
            end
         end
      end
   endtask

   task automatic run_cmd(int code, string req);
      bus_write(0, code);
      wait_idle(req);
      model_cmd(code);
   endtask

   function automatic string op_req(int op);
      if (op == 0) return "R3";
      if (op <= 4) return "R4";
      if (op <= 8) return "R5";
      return "R6";
   endfunction

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int d;
      rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; disp_idx = '0;
      for (int i = 0; i < CELLS; i++) begin
         m_c[i] = 8'h20; m_k[i] = 0; s_c[i] = 8'h20; s_k[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: reset state
      for (int off = 0; off <= 8; off++) begin
         bus_read(off, d);
         check("R1", d, 0, $sformatf("register %0d", off));
      end
      compare_all("R1");

      // R2: register readback
      set_reg(7, 8'hFF); bus_read(7, d); check("R2", d, 8'h0F, "colour low nibble");
      set_reg(3, 8'hC8); bus_read(3, d); check("R2", d, 8'hC8, "window X raw");
      set_reg(6, 8'h11); bus_read(6, d); check("R2", d, 8'h11, "window H raw");
      set_reg(8, 8'h03); bus_read(8, d); check("R2", d, 1, "mode bit");
      set_reg(8, 0);     bus_read(8, d); check("R2", d, 0, "mode char");

      // R11 / R12: plane access by bus and display port
      fill_planes(5);
      bus_read(12'h400, d);       check("R11", d, m_c[0], "char 0");
      bus_read(12'h400 + 519, d); check("R11", d, m_c[519], "char 519");
      bus_read(12'h800 + 100, d); check("R11", d, m_k[100], "colour 100");
      compare_all("R12");

      // R3..R6: full-screen operations
      for (int op = 1; op <= 10; op++) begin
         fill_planes(op * 11);
         run_cmd(op, op_req(op));
         compare_all(op_req(op));
      end
      set_reg(7, 5);
      fill_planes(3);
      run_cmd(0, "R3");
      compare_all("R3");

      // R7: windowed operations
      set_reg(3, 3); set_reg(4, 2); set_reg(5, 7); set_reg(6, 4);
      for (int op = 0; op <= 10; op++) begin
         fill_planes(op * 13 + 1);
         run_cmd(16 | op, "R7");
         compare_all("R7");
      end

      // R8: clamping and empty windows
      set_reg(3, 35); set_reg(4, 10); set_reg(5, 10); set_reg(6, 9);
      fill_planes(41);
      run_cmd(8'h15, "R8"); compare_all("R8");
      run_cmd(8'h18, "R8"); compare_all("R8");
      set_reg(3, 40); set_reg(4, 0); set_reg(5, 5); set_reg(6, 5);
      run_cmd(8'h19, "R8"); compare_all("R8");
      set_reg(3, 5); set_reg(4, 13);
      run_cmd(8'h10, "R8"); compare_all("R8");
      set_reg(4, 5); set_reg(5, 0);
      run_cmd(8'h10, "R8"); compare_all("R8");

      // R9: busy readback and dropped accesses
      fill_planes(60);
      bus_write(0, 8'h00);
      bus_read(0, d); check("R9", d & 1, 1, "busy while running");
      bus_write(0, 8'h09);
      bus_write(12'h400 + 7, 8'hAB);
      bus_write(2, 8'h00);
      wait_idle("R9");
      model_cmd(8'h00);
      compare_all("R9");
      set_reg(1, 1);
      compare_all("R9");
      set_reg(1, 0);
      bus_write(0, 8'h0B);
      bus_read(0, d); check("R9", d & 1, 0, "undefined code idle");
      bus_write(0, 8'hE1);
      bus_read(0, d); check("R9", d & 1, 0, "high bits code idle");
      compare_all("R9");

      // R10: snapshot and pause
      fill_planes(77);
      set_reg(2, 8'h5A);
      wait_idle("R10");
      s_c = m_c; s_k = m_k;
      set_reg(1, 1);
      bus_read(1, d); check("R10", d, 1, "pause readback");
      run_cmd(8'h09, "R10");
      compare_all("R10");
      set_reg(2, 8'h00);
      wait_idle("R10");
      s_c = m_c; s_k = m_k;
      compare_all("R10");
      set_reg(1, 0);
      run_cmd(8'h05, "R10");
      compare_all("R10");

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule